// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block produces the interrupt lines of a serial-bus peripheral. It watches the live fill levels of two queues: a format queue, which feeds commands to the bus engine, and a receive queue, which collects bytes read from the bus. Each fill level is compared against a level that software selects with a small code. The format queue raises its interrupt when it drains below its level. The receive queue raises its interrupt when it fills above its level.

The same block also gathers single-cycle event pulses from the bus engines and two level-status signals. It keeps them in one 15-bit state register. Event bits stay set until software writes 1 to them. Status bits simply follow their source. A write-only test register lets software force any state bit high. An enable register gates each state bit onto its own interrupt output.

Software reaches the registers through a plain write strobe with an address and a combinational read port. There are four word addresses: 0 is state, 1 is enable, 2 is test and 3 is level select.

Top module: `irq_thr_ctrl`

## Requirements
- R1: While reset is held, and right after it, the state and enable registers read 0, the level-select register reads 0 and every interrupt output is 0.
- R2: Level-select bits [5:4] hold the format code. Codes 0, 1, 2 and 3 select 1, 4, 8 and 16 entries. State bit 0 sets at the clock edge where the format fill level first becomes smaller than the selected count.
- R3: Level-select bits [2:0] hold the receive code. Codes 0 to 4 select 1, 4, 8, 16 and 30 entries. State bit 1 sets at the clock edge where the receive fill level first becomes larger than the selected count.
- R4: Receive codes 5, 6 and 7 behave exactly like code 4 (30 entries).
- R5: The threshold bits (0 and 1) react only to a new false-to-true change of their comparison. Once cleared, they stay 0 while the comparison remains true.
- R6: An event_pulse on bits 2–9, 11, 13 or 14 sets that state bit at the next edge. The bit stays set until a write to address 0 with a 1 in that position.
- R7: When a hardware set and a software clear hit the same state bit in the same cycle, the bit ends up set.
- R8: State bit 10 follows stretch_active and state bit 12 follows acq_at_full, each one cycle late. Writing 1 to these bits at address 0 has no effect on them.
- R9: Writing 1 to a bit at address 2 makes the matching state bit 1 after the write edge. Address 2 always reads 0.
- R10: Each irq bit is 1 exactly when both its state bit and its enable bit (address 1) are 1.
- R11: event_pulse bits 0, 1, 10 and 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W (3) | Word address: 0 state, 1 enable, 2 test, 3 level select |
| csr_wdata | input | DATA_W (32) | Write data |
| csr_rdata | output | DATA_W (32) | Read data for csr_addr (combinational) |
| fmt_level | input | DEPTH_W (7) | Live fill level of the format queue |
| rx_level | input | DEPTH_W (7) | Live fill level of the receive queue |
| event_pulse | input | 15 | One-cycle event pulses from the bus engines, one per state bit |
| stretch_active | input | 1 | Level status: the target is holding the clock for a read |
| acq_at_full | input | 1 | Level status: the acquired-data queue is full |
| irq | output | 15 | Interrupt lines, state AND enable |

## Verification
The bench builds the block with its default parameters: 7-bit fill levels, a 32-bit data word and a 3-bit address. The 7-bit level width lets the bench drive a receive depth of 31, just past the largest level of 30, and a format depth of 127, which can never trigger. This makes it possible to probe both sides of every level code, including the reserved receive codes. A vector table walks each code at the depth where the comparison flips. Directed tests then cover edge-only re-arming, the same-cycle set-versus-clear race, the status bits that ignore clears, test forcing and enable gating.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

   localparam int IRQ_N          = 15;
   localparam int IRQ_FMT_THR    = 0;
   localparam int IRQ_RX_THR     = 1;
   localparam int IRQ_TX_STRETCH = 10;
   localparam int IRQ_ACQ_FULL   = 12;

   localparam int FMT_CODE_W = 2;
   localparam int RX_CODE_W  = 3;
   localparam int LIMIT_W    = 8;

   localparam int REG_STATE  = 0;
   localparam int REG_ENABLE = 1;
   localparam int REG_TEST   = 2;
   localparam int REG_LEVEL  = 3;

   // bit positions of the codes inside the level-select word
   localparam int RX_CODE_LSB  = 0;
   localparam int FMT_CODE_LSB = 4;
   localparam int LEVEL_REG_W  = FMT_CODE_LSB + FMT_CODE_W;

   typedef enum logic {CELL_STICKY, CELL_FOLLOW} cell_kind_e;

   typedef struct packed {
      logic [FMT_CODE_W-1:0] fmt_code;
      logic [RX_CODE_W-1:0]  rx_code;
   } lvl_cfg_t;

   function automatic logic [LIMIT_W-1:0] fmt_code_limit(input logic [FMT_CODE_W-1:0] code);
      case (code)
         2'd0:    return 8'd1;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd16;
      endcase
   endfunction

   function automatic logic [LIMIT_W-1:0] rx_code_limit(input logic [RX_CODE_W-1:0] code);
      case (code)
         3'd0:    return 8'd1;
         3'd1:    return 8'd4;
         3'd2:    return 8'd8;
         3'd3:    return 8'd16;
         default: return 8'd30;   // code 4 and the reserved codes
      endcase
   endfunction

   function automatic bit is_status_bit(input int idx);
      return (idx == IRQ_TX_STRETCH) || (idx == IRQ_ACQ_FULL);
   endfunction

endpackage

// File: rtl/thr_compare.sv
module thr_compare
   import irq_thr_pkg::*;
#(
   parameter int DEPTH_W = 7,
   parameter int CODE_W  = 2,
   parameter bit ABOVE   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] depth,
   input  logic [CODE_W-1:0]  code,
   output logic               set_pulse
);

   localparam int CMP_W = (DEPTH_W > LIMIT_W) ? DEPTH_W : LIMIT_W;

   logic [LIMIT_W-1:0] limit;
   logic               cond;
   logic               cond_q;

   generate
      if (ABOVE) begin : g_above
         if (CODE_W != RX_CODE_W) begin : g_bad_w
            $error("thr_compare: receive variant needs a 3-bit code");
         end
         assign limit = rx_code_limit(code);
         assign cond  = CMP_W'(depth) > CMP_W'(limit);
      end else begin : g_below
         if (CODE_W != FMT_CODE_W) begin : g_bad_w
            $error("thr_compare: format variant needs a 2-bit code");
         end
         assign limit = fmt_code_limit(code);
         assign cond  = CMP_W'(depth) < CMP_W'(limit);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign set_pulse = cond & ~cond_q;

   // R5: a set pulse is a single cycle wide; a persisting condition cannot re-arm
   assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> !set_pulse);

endmodule

// File: rtl/irq_cell.sv
module irq_cell
   import irq_thr_pkg::*;
#(
   parameter cell_kind_e KIND = CELL_STICKY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   input  logic sw_force,
   output logic state
);

   logic state_q;

   generate
      if (KIND == CELL_STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= 1'b0;
            else        state_q <= (state_q & ~sw_clr) | hw_set | sw_force;
         end

         // R6: a set bit survives every cycle without a clear
         assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q && !sw_clr) |=> state_q);
         // R7: a hardware set is never lost, even to a same-cycle clear
         assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> state_q);
      end else begin : g_follow
         logic unused_clr;
         assign unused_clr = sw_clr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= 1'b0;
            else        state_q <= hw_set | sw_force;
         end

         // R8: a status bit drops once its source and the force are both low
         assert_follow_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!hw_set && !sw_force) |=> !state_q);
         assert_follow_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> state_q);
      end
   endgenerate

   assign state = state_q;

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_thr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IRQ_N-1:0]  state,
   output logic [DATA_W-1:0] rdata,
   output logic [IRQ_N-1:0]  clr_vec,
   output logic [IRQ_N-1:0]  force_vec,
   output logic [IRQ_N-1:0]  enable,
   output lvl_cfg_t          lvl_cfg
);

   generate
      if (DATA_W < IRQ_N || DATA_W < LEVEL_REG_W) begin : g_bad_data
         $error("irq_reg_port: data word too narrow");
      end
      if ((1 << ADDR_W) <= REG_LEVEL) begin : g_bad_addr
         $error("irq_reg_port: address too narrow");
      end
   endgenerate

   logic hit_state, hit_enable, hit_test, hit_level;
   logic [IRQ_N-1:0] enable_q;
   lvl_cfg_t         lvl_q;
   logic             unused_wdata;

   assign hit_state  = (addr == ADDR_W'(REG_STATE));
   assign hit_enable = (addr == ADDR_W'(REG_ENABLE));
   assign hit_test   = (addr == ADDR_W'(REG_TEST));
   assign hit_level  = (addr == ADDR_W'(REG_LEVEL));

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         lvl_q    <= '0;
      end else if (we) begin
         if (hit_enable) enable_q <= wdata[IRQ_N-1:0];
         if (hit_level) begin
            lvl_q.rx_code  <= wdata[RX_CODE_LSB +: RX_CODE_W];
            lvl_q.fmt_code <= wdata[FMT_CODE_LSB +: FMT_CODE_W];
         end
      end
   end

   assign clr_vec   = (we && hit_state) ? wdata[IRQ_N-1:0] : '0;
   assign force_vec = (we && hit_test)  ? wdata[IRQ_N-1:0] : '0;
   assign enable    = enable_q;
   assign lvl_cfg   = lvl_q;

   always_comb begin
      rdata = '0;
      if (hit_state)  rdata[IRQ_N-1:0] = state;
      if (hit_enable) rdata[IRQ_N-1:0] = enable_q;
      if (hit_level) begin
         rdata[RX_CODE_LSB +: RX_CODE_W]   = lvl_q.rx_code;
         rdata[FMT_CODE_LSB +: FMT_CODE_W] = lvl_q.fmt_code;
      end
   end

   // R9: the test address never returns data
   assert_test_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_test |-> (rdata == '0));

endmodule

// File: rtl/irq_thr_ctrl.sv
module irq_thr_ctrl
   import irq_thr_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int DEPTH_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_we,
   input  logic [ADDR_W-1:0]  csr_addr,
   input  logic [DATA_W-1:0]  csr_wdata,
   output logic [DATA_W-1:0]  csr_rdata,
   input  logic [DEPTH_W-1:0] fmt_level,
   input  logic [DEPTH_W-1:0] rx_level,
   input  logic [IRQ_N-1:0]   event_pulse,
   input  logic               stretch_active,
   input  logic               acq_at_full,
   output logic [IRQ_N-1:0]   irq
);

   generate
      if (DEPTH_W < 5) begin : g_bad_depth
         $error("irq_thr_ctrl: fill level must reach beyond 30");
      end
   endgenerate

   logic [IRQ_N-1:0] state;
   logic [IRQ_N-1:0] clr_vec;
   logic [IRQ_N-1:0] force_vec;
   logic [IRQ_N-1:0] enable;
   logic [IRQ_N-1:0] hw_set;
   lvl_cfg_t         lvl_cfg;
   logic             fmt_set;
   logic             rx_set;
   logic             unused_evt;

   irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (csr_we),
      .addr      (csr_addr),
      .wdata     (csr_wdata),
      .state     (state),
      .rdata     (csr_rdata),
      .clr_vec   (clr_vec),
      .force_vec (force_vec),
      .enable    (enable),
      .lvl_cfg   (lvl_cfg)
   );

   thr_compare #(.DEPTH_W(DEPTH_W), .CODE_W(FMT_CODE_W), .ABOVE(1'b0)) u_fmt_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .depth     (fmt_level),
      .code      (lvl_cfg.fmt_code),
      .set_pulse (fmt_set)
   );

   thr_compare #(.DEPTH_W(DEPTH_W), .CODE_W(RX_CODE_W), .ABOVE(1'b1)) u_rx_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .depth     (rx_level),
      .code      (lvl_cfg.rx_code),
      .set_pulse (rx_set)
   );

   // event_pulse positions owned by comparators or status inputs are dropped
   assign unused_evt = event_pulse[IRQ_FMT_THR] ^ event_pulse[IRQ_RX_THR]
                     ^ event_pulse[IRQ_TX_STRETCH] ^ event_pulse[IRQ_ACQ_FULL];

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
         if (i == IRQ_FMT_THR) begin : g_src
            assign hw_set[i] = fmt_set;
         end else if (i == IRQ_RX_THR) begin : g_src
            assign hw_set[i] = rx_set;
         end else if (i == IRQ_TX_STRETCH) begin : g_src
            assign hw_set[i] = stretch_active;
         end else if (i == IRQ_ACQ_FULL) begin : g_src
            assign hw_set[i] = acq_at_full;
         end else begin : g_src
            assign hw_set[i] = event_pulse[i];
         end

         irq_cell #(.KIND(is_status_bit(i) ? CELL_FOLLOW : CELL_STICKY)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_set   (hw_set[i]),
            .sw_clr   (clr_vec[i]),
            .sw_force (force_vec[i]),
            .state    (state[i])
         );
      end
   endgenerate

   assign irq = state & enable;

   // R10: bits written 0 into the enable register are silent on the next cycle
   assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == ADDR_W'(REG_ENABLE))
         |=> ((irq & ~$past(csr_wdata[IRQ_N-1:0])) == '0));

endmodule

// File: tb/irq_thr_ctrl_test.sv
`timescale 1ns/1ps
module irq_thr_ctrl_test;

   localparam int AW = 3;
   localparam int DW = 32;
   localparam int LW = 7;
   localparam int NI = 15;
   localparam int NVEC = 22;

   // {is_rx, code[2:0], depth[6:0], expected threshold bit}
   localparam logic [11:0] VEC [0:NVEC-1] = '{
      {1'b0, 3'd0, 7'd0,  1'b1}, {1'b0, 3'd0, 7'd1,  1'b0},
      {1'b0, 3'd1, 7'd3,  1'b1}, {1'b0, 3'd1, 7'd4,  1'b0},
      {1'b0, 3'd2, 7'd7,  1'b1}, {1'b0, 3'd2, 7'd8,  1'b0},
      {1'b0, 3'd3, 7'd15, 1'b1}, {1'b0, 3'd3, 7'd16, 1'b0},
      {1'b1, 3'd0, 7'd1,  1'b0}, {1'b1, 3'd0, 7'd2,  1'b1},
      {1'b1, 3'd1, 7'd4,  1'b0}, {1'b1, 3'd1, 7'd5,  1'b1},
      {1'b1, 3'd2, 7'd8,  1'b0}, {1'b1, 3'd2, 7'd9,  1'b1},
      {1'b1, 3'd3, 7'd16, 1'b0}, {1'b1, 3'd3, 7'd17, 1'b1},
      {1'b1, 3'd4, 7'd30, 1'b0}, {1'b1, 3'd4, 7'd31, 1'b1},
      {1'b1, 3'd5, 7'd30, 1'b0}, {1'b1, 3'd5, 7'd31, 1'b1},
      {1'b1, 3'd6, 7'd30, 1'b0}, {1'b1, 3'd7, 7'd31, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_we = 1'b0;
   logic [AW-1:0] csr_addr = '0;
   logic [DW-1:0] csr_wdata = '0;
   logic [DW-1:0] csr_rdata;
   logic [LW-1:0] fmt_level = 7'd10;
   logic [LW-1:0] rx_level = 7'd0;
   logic [NI-1:0] event_pulse = '0;
   logic          stretch_active = 1'b0;
   logic          acq_at_full = 1'b0;
   logic [NI-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_thr_ctrl uut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fmt_level(fmt_level),
      .rx_level(rx_level), .event_pulse(event_pulse),
      .stretch_active(stretch_active), .acq_at_full(acq_at_full), .irq(irq)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      csr_we = 1'b1; csr_addr = AW'(a); csr_wdata = d;
      tick();
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      csr_addr = AW'(a);
      #1;
      d = csr_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      // R1 reset state
      repeat (2) @(posedge clk);
      #1;
      rd(0, r); check("R1 state in reset", r, 0);
      rd(1, r); check("R1 enable in reset", r, 0);
      check("R1 irq in reset", {17'b0, irq}, 0);
      rst_n = 1'b1;
      tick();
      rd(0, r); check("R1 state after reset", r, 0);
      rd(3, r); check("R1 level select after reset", r, 0);
      fmt_level = 7'd127;
      tick();

      // R2 R3 R4 threshold vectors
      for (int i = 0; i < NVEC; i++) begin
         logic [11:0] v;
         v = VEC[i];
         fmt_level = 7'd127; rx_level = 7'd0;
         tick();
         if (v[11]) wr(3, {29'b0, v[10:8]});
         else       wr(3, {26'b0, v[9:8], 4'b0});
         wr(0, 32'h3);
         if (v[11]) rx_level = v[7:1];
         else       fmt_level = v[7:1];
         tick(); tick();
         rd(0, r);
         if (v[11]) check(v[10:8] > 3'd4 ? "R4 reserved rx code" : "R3 rx threshold", {31'b0, r[1]}, {31'b0, v[0]});
         else       check("R2 fmt threshold", {31'b0, r[0]}, {31'b0, v[0]});
      end

      // R5 edge-only re-arm
      fmt_level = 7'd127; rx_level = 7'd0;
      wr(3, 32'h0);
      wr(0, 32'h7fff);
      fmt_level = 7'd0;
      tick();
      rd(0, r); check("R5 fmt set on edge", {31'b0, r[0]}, 1);
      wr(0, 32'h1);
      tick(); tick(); tick();
      rd(0, r); check("R5 stays clear while condition holds", {31'b0, r[0]}, 0);
      fmt_level = 7'd10; tick();
      fmt_level = 7'd0;  tick();
      rd(0, r); check("R5 re-armed after new edge", {31'b0, r[0]}, 1);
      fmt_level = 7'd127; tick();
      wr(0, 32'h7fff);

      // R6 sticky event set and clear
      event_pulse = 15'h0004; tick(); event_pulse = '0;
      tick(); tick();
      rd(0, r); check("R6 event bit sticky", r, 32'h0004);
      wr(0, 32'h0004);
      rd(0, r); check("R6 event bit cleared", r, 0);
      event_pulse = 15'h6800; tick(); event_pulse = '0;
      rd(0, r); check("R6 high event bits", r, 32'h6800);
      wr(0, 32'h6800);

      // R7 set beats clear
      event_pulse = 15'h0020;
      wr(0, 32'h0020);
      event_pulse = '0;
      rd(0, r); check("R7 set wins over clear", r, 32'h0020);
      wr(0, 32'h0020);

      // R8 status bits follow and ignore clears
      stretch_active = 1'b1; tick();
      rd(0, r); check("R8 stretch follows", r, 32'h0400);
      wr(0, 32'h0400);
      rd(0, r); check("R8 clear ignored on status bit", r, 32'h0400);
      stretch_active = 1'b0; tick();
      rd(0, r); check("R8 stretch drops", r, 0);
      acq_at_full = 1'b1; tick();
      rd(0, r); check("R8 acq full follows", r, 32'h1000);
      acq_at_full = 1'b0; tick();
      rd(0, r); check("R8 acq full drops", r, 0);

      // R9 test forcing
      wr(2, 32'h0181);
      rd(0, r); check("R9 forced bits", r, 32'h0181);
      rd(2, r); check("R9 test reads zero", r, 0);
      wr(2, 32'h0400);
      rd(0, r); check("R9 forced status bit", r, 32'h0581);
      tick();
      rd(0, r); check("R9 status bit returns to source", r, 32'h0181);
      wr(0, 32'h7fff);

      // R10 enable gating
      wr(1, 32'h0020);
      rd(1, r); check("R10 enable readback", r, 32'h0020);
      event_pulse = 15'h0060; tick(); event_pulse = '0;
      check("R10 irq gated", {17'b0, irq}, 32'h0020);
      wr(1, 32'h0);
      check("R10 irq off when disabled", {17'b0, irq}, 0);
      rd(0, r); check("R10 state kept while disabled", r, 32'h0060);
      wr(0, 32'h7fff);

      // R11 ignored event positions
      wr(1, 32'h7fff);
      event_pulse = 15'h1403; tick(); event_pulse = '0;
      tick();
      rd(0, r); check("R11 ignored event bits", r, 0);
      check("R11 irq stays low", {17'b0, irq}, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule